// File: doc/BRIEF.md
# Atomic Read-Modify-Write Sequencer

This unit performs one atomic memory operation at a time on behalf of an execution pipeline. The pipeline hands it a base register, a signed 16-bit displacement, a width code, an operation immediate, the source register value and the current value of register zero. The unit reads the target location, works out the new value, and writes it back. It holds a lock line on the single-port memory from the read request until the write is acknowledged. It then returns one response that says which architectural register, if any, should take the old memory value.

The simple operations are add, or, and and exclusive-or. Each can optionally fetch the old value back into the source register. Exchange always stores the source value and returns the old value to the source register. Compare-exchange compares memory with register zero, stores the source value only when they are equal, and always hands the old value to register zero. An illegal immediate or width gets an immediate error response and never touches memory.

Top module: `amo_unit`

## Requirements
- R1: After reset `req_ready`=1, `rsp_valid`=0, `mem_req`=0 and `mem_lock`=0. A request is taken only when `req_valid` and `req_ready` are both high, and `req_ready` stays low until the response cycle is over.
- R2: The memory address equals `req_base` plus `req_offset` sign-extended to 64 bits, and it stays stable while the lock is held.
- R3: Immediate 0x00 adds, 0x40 ors, 0x50 ands and 0xA0 exclusive-ors the source value into memory. With immediate bit 0 clear, neither `rsp_wr_src` nor `rsp_wr_r0` is set.
- R4: The same four codes with bit 0 set (0x01, 0x41, 0x51, 0xA1) perform the same update, set `rsp_wr_src`, and return the old memory value on `rsp_data`.
- R5: Immediate 0xE1 writes the source value to memory, sets `rsp_wr_src`, and returns the old value.
- R6: Immediate 0xF1 compares memory with `req_r0`. On equality it writes the source value. In both cases it sets `rsp_wr_r0` and returns the old value.
- R7: A compare-exchange whose compare fails issues no write, drops the lock, and responds 5 cycles after acceptance when memory acknowledges one cycle after a request.
- R8: `req_size` 2'b11 is 64-bit and 2'b00 is 32-bit (these are opcode bits 4:3). In 32-bit mode only the low 32 bits are compared and computed, `mem_wide`=0, the upper half of `mem_wdata` is zero, and `rsp_data` is zero-extended.
- R9: Any other immediate, a nonzero immediate bit above bit 7, or `req_size` 2'b01 or 2'b10 gives `rsp_valid` with `rsp_err`=1 and `rsp_data`=0 in the cycle right after acceptance, with no memory request.
- R10: `mem_lock` is high on every memory request and stays high from the read request until the write acknowledge.
- R11: Each memory request is a one-cycle pulse. The response comes one cycle after the write acknowledge, which is 6+2·D cycles after acceptance for a memory that acknowledges D cycles after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operation request |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_base | input | 64 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_size | input | 2 | Width code: 00 = 32-bit, 11 = 64-bit |
| req_imm | input | 32 | Operation immediate |
| req_src | input | 64 | Source register value |
| req_r0 | input | 64 | Register zero value (compare operand) |
| mem_req | output | 1 | Memory request pulse |
| mem_we | output | 1 | Request is a write |
| mem_wide | output | 1 | Access is 64-bit |
| mem_lock | output | 1 | Memory port locked |
| mem_addr | output | 64 | Byte address |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 64 | Read data, valid with acknowledge |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_err | output | 1 | Request rejected |
| rsp_wr_src | output | 1 | Write rsp_data to the source register |
| rsp_wr_r0 | output | 1 | Write rsp_data to register zero |
| rsp_data | output | 64 | Old memory value |

## Verification
Every result has a fixed due cycle. Counting the acceptance edge as the first, a rejection answers after 1 edge, a failed compare after 4+D edges, and a full read-modify-write after 6+2·D edges, where D is the acknowledge delay of the bench memory. The bench drives requests and samples on falling edges. It counts rising edges from acceptance to the response strobe and compares that count with these formulas, for D=1 and for D=3. It checks memory contents, the number of memory requests and the lock level seen at the write request right after each response.

// File: rtl/amo_pkg.sv
package amo_pkg;

  typedef enum logic [2:0] {
    OP_ADD,
    OP_OR,
    OP_AND,
    OP_XOR,
    OP_XCHG,
    OP_CMPX
  } amo_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT_RD,
    ST_COMPUTE,
    ST_WRITE,
    ST_WAIT_WR,
    ST_DONE
  } amo_state_e;

  localparam logic [1:0] SIZE_WORD  = 2'b00;
  localparam logic [1:0] SIZE_DWORD = 2'b11;

endpackage

// File: rtl/amo_decode.sv
module amo_decode
  import amo_pkg::*;
#(
  parameter int IMM_W = 32
) (
  input  logic [IMM_W-1:0] imm,
  input  logic [1:0]       size,
  output amo_op_e          op,
  output logic             fetch,
  output logic             wide,
  output logic             legal
);

  logic imm_ok;
  logic size_ok;

  always_comb begin
    op     = OP_ADD;
    imm_ok = 1'b1;
    case (imm[7:0])
      8'h00, 8'h01: op = OP_ADD;
      8'h40, 8'h41: op = OP_OR;
      8'h50, 8'h51: op = OP_AND;
      8'hA0, 8'hA1: op = OP_XOR;
      8'hE1:        op = OP_XCHG;
      8'hF1:        op = OP_CMPX;
      default:      imm_ok = 1'b0;
    endcase
    if (imm[IMM_W-1:8] != '0) imm_ok = 1'b0;
  end

  assign size_ok = (size == SIZE_WORD) || (size == SIZE_DWORD);
  assign wide    = (size == SIZE_DWORD);
  assign fetch   = imm[0];
  assign legal   = imm_ok && size_ok;

endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  amo_op_e           op,
  input  logic              wide,
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] src_val,
  input  logic [DATA_W-1:0] cmp_val,
  output logic [DATA_W-1:0] new_val,
  output logic              cmp_hit
);

  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] old_m;
  logic [DATA_W-1:0] src_m;
  logic [DATA_W-1:0] raw;

  always_comb begin
    if (wide) begin
      old_m = old_val;
      src_m = src_val;
    end else begin
      old_m = {{HALF_W{1'b0}}, old_val[HALF_W-1:0]};
      src_m = {{HALF_W{1'b0}}, src_val[HALF_W-1:0]};
    end
  end

  always_comb begin
    case (op)
      OP_ADD:  raw = old_m + src_m;
      OP_OR:   raw = old_m | src_m;
      OP_AND:  raw = old_m & src_m;
      OP_XOR:  raw = old_m ^ src_m;
      default: raw = src_m;
    endcase
    new_val = wide ? raw : {{HALF_W{1'b0}}, raw[HALF_W-1:0]};
  end

  assign cmp_hit = wide ? (old_val == cmp_val)
                        : (old_val[HALF_W-1:0] == cmp_val[HALF_W-1:0]);

endmodule

// File: rtl/amo_fsm.sv
module amo_fsm
  import amo_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_legal,
  input  logic skip_write,
  input  logic mem_ack,
  output logic idle,
  output logic mem_req,
  output logic mem_we,
  output logic mem_lock,
  output logic cap_old,
  output logic cap_new,
  output logic rsp_valid
);

  amo_state_e state_q;
  amo_state_e state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (start) state_d = start_legal ? ST_READ : ST_DONE;
      ST_READ:    state_d = ST_WAIT_RD;
      ST_WAIT_RD: if (mem_ack) state_d = ST_COMPUTE;
      ST_COMPUTE: state_d = skip_write ? ST_DONE : ST_WRITE;
      ST_WRITE:   state_d = ST_WAIT_WR;
      ST_WAIT_WR: if (mem_ack) state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign idle      = (state_q == ST_IDLE);
  assign mem_req   = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign mem_we    = (state_q == ST_WRITE);
  assign mem_lock  = (state_q == ST_READ) || (state_q == ST_WAIT_RD) ||
                     (state_q == ST_COMPUTE) || (state_q == ST_WRITE) ||
                     (state_q == ST_WAIT_WR);
  assign cap_old   = (state_q == ST_WAIT_RD) && mem_ack;
  assign cap_new   = (state_q == ST_COMPUTE);
  assign rsp_valid = (state_q == ST_DONE);

  // R11: requests are single-cycle pulses
  a_r11_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R10: a request is only issued under the lock
  a_r10_lock_on_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_lock);

  // R10: the lock is held until the write acknowledge
  a_r10_hold_to_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_lock && mem_we) |=> mem_lock);

endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64,
  parameter int OFF_W  = 16,
  parameter int IMM_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [1:0]        req_size,
  input  logic [IMM_W-1:0]  req_imm,
  input  logic [DATA_W-1:0] req_src,
  input  logic [DATA_W-1:0] req_r0,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_wide,
  output logic              mem_lock,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic              rsp_wr_src,
  output logic              rsp_wr_r0,
  output logic [DATA_W-1:0] rsp_data
);

  localparam int HALF_W = DATA_W / 2;
  localparam int EXT_W  = ADDR_W - OFF_W;

  amo_op_e dec_op;
  logic    dec_fetch;
  logic    dec_wide;
  logic    dec_legal;
  logic    start;
  logic    idle;
  logic    cap_old;
  logic    cap_new;
  logic    hit;
  logic    skip_write;
  logic [DATA_W-1:0] alu_new;
  logic [ADDR_W-1:0] ea;

  amo_op_e           op_q;
  logic              fetch_q;
  logic              wide_q;
  logic              err_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] src_q;
  logic [DATA_W-1:0] r0_q;
  logic [DATA_W-1:0] old_q;
  logic [DATA_W-1:0] new_q;

  amo_decode #(.IMM_W(IMM_W)) u_dec (
    .imm   (req_imm),
    .size  (req_size),
    .op    (dec_op),
    .fetch (dec_fetch),
    .wide  (dec_wide),
    .legal (dec_legal)
  );

  amo_alu #(.DATA_W(DATA_W)) u_alu (
    .op      (op_q),
    .wide    (wide_q),
    .old_val (old_q),
    .src_val (src_q),
    .cmp_val (r0_q),
    .new_val (alu_new),
    .cmp_hit (hit)
  );

  amo_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .start_legal (dec_legal),
    .skip_write  (skip_write),
    .mem_ack     (mem_ack),
    .idle        (idle),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_lock    (mem_lock),
    .cap_old     (cap_old),
    .cap_new     (cap_new),
    .rsp_valid   (rsp_valid)
  );

  assign start      = req_valid && idle;
  assign req_ready  = idle;
  assign ea         = req_base + {{EXT_W{req_offset[OFF_W-1]}}, req_offset};
  assign skip_write = (op_q == OP_CMPX) && !hit;

  // request capture, enabled on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_ADD;
      fetch_q <= 1'b0;
      wide_q  <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= '0;
      src_q   <= '0;
      r0_q    <= '0;
    end else if (start) begin
      op_q    <= dec_op;
      fetch_q <= dec_fetch;
      wide_q  <= dec_wide;
      err_q   <= !dec_legal;
      addr_q  <= ea;
      src_q   <= req_src;
      r0_q    <= req_r0;
    end
  end

  // old value, enabled on read acknowledge; cleared on a rejected request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      old_q <= '0;
    end else if (start && !dec_legal) begin
      old_q <= '0;
    end else if (cap_old) begin
      old_q <= wide_q ? mem_rdata : {{HALF_W{1'b0}}, mem_rdata[HALF_W-1:0]};
    end
  end

  // new value, enabled in the compute cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       new_q <= '0;
    else if (cap_new) new_q <= alu_new;
  end

  assign mem_addr   = addr_q;
  assign mem_wdata  = new_q;
  assign mem_wide   = wide_q;
  assign rsp_err    = rsp_valid && err_q;
  assign rsp_wr_src = rsp_valid && !err_q &&
                      ((op_q == OP_XCHG) || ((op_q != OP_CMPX) && fetch_q));
  assign rsp_wr_r0  = rsp_valid && !err_q && (op_q == OP_CMPX);
  assign rsp_data   = rsp_valid ? old_q : '0;

  // R9: a rejected request never holds the port
  a_r9_err_no_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (!mem_lock && !mem_req));

  // R8: 32-bit writes carry a zero upper half
  a_r8_word_wdata: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !mem_wide) |-> (mem_wdata[DATA_W-1:HALF_W] == '0));

  // R8: 32-bit responses are zero-extended
  a_r8_word_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !mem_wide) |-> (rsp_data[DATA_W-1:HALF_W] == '0));

  // R2: address held for the whole locked sequence
  a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_lock && $past(mem_lock)) |-> $stable(mem_addr));

  // R6: at most one register destination per response
  a_r6_one_dest: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot0({rsp_wr_src, rsp_wr_r0, rsp_err}));

endmodule

// File: tb/tb_amo_unit.sv
module tb_amo_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [63:0] req_base;
  logic [15:0] req_offset;
  logic [1:0]  req_size;
  logic [31:0] req_imm;
  logic [63:0] req_src;
  logic [63:0] req_r0;
  logic        mem_req;
  logic        mem_we;
  logic        mem_wide;
  logic        mem_lock;
  logic [63:0] mem_addr;
  logic [63:0] mem_wdata;
  logic        mem_ack;
  logic [63:0] mem_rdata;
  logic        rsp_valid;
  logic        rsp_err;
  logic        rsp_wr_src;
  logic        rsp_wr_r0;
  logic [63:0] rsp_data;

  amo_unit dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_base(req_base), .req_offset(req_offset), .req_size(req_size),
    .req_imm(req_imm), .req_src(req_src), .req_r0(req_r0),
    .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide),
    .mem_lock(mem_lock), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_wr_src(rsp_wr_src),
    .rsp_wr_r0(rsp_wr_r0), .rsp_data(rsp_data)
  );

  int checks = 0;
  int fails  = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // bench memory: 16 slots of 8 bytes, ack after ack_delay cycles
  logic [63:0] bm [16];
  int          ack_delay = 1;
  int          nreq = 0;
  int          nwr = 0;
  logic        wr_lock = 1'b0;
  logic        pend = 1'b0;
  int          cnt = 0;
  logic [3:0]  pidx = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      pend    <= 1'b0;
    end else begin
      mem_ack <= 1'b0;
      if (mem_req) begin
        nreq <= nreq + 1;
        pend <= 1'b1;
        cnt  <= ack_delay;
        pidx <= mem_addr[6:3];
        if (mem_we) begin
          nwr     <= nwr + 1;
          wr_lock <= mem_lock;
          if (mem_wide) bm[mem_addr[6:3]] <= mem_wdata;
          else          bm[mem_addr[6:3]][31:0] <= mem_wdata[31:0];
        end
      end else if (pend) begin
        if (cnt <= 1) begin
          mem_ack   <= 1'b1;
          mem_rdata <= bm[pidx];
          pend      <= 1'b0;
        end else begin
          cnt <= cnt - 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // results of the last operation
  int          r_lat;
  logic        r_err, r_wsrc, r_wr0, r_busy;
  logic [63:0] r_data;
  int          r_nreq, r_nwr;

  task automatic run(input logic [63:0] base, input logic [15:0] off,
                     input logic [1:0] size, input logic [31:0] imm,
                     input logic [63:0] src, input logic [63:0] r0);
    int n0, w0;
    @(negedge clk);
    n0 = nreq; w0 = nwr;
    req_base = base; req_offset = off; req_size = size;
    req_imm = imm; req_src = src; req_r0 = r0; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    r_busy = !req_ready;
    r_lat = 1;
    while (!rsp_valid && r_lat < 100) begin
      @(posedge clk); r_lat++; @(negedge clk);
    end
    r_err = rsp_err; r_wsrc = rsp_wr_src; r_wr0 = rsp_wr_r0; r_data = rsp_data;
    @(negedge clk);
    r_nreq = nreq - n0; r_nwr = nwr - w0;
  endtask

  task automatic t_reset;
    chk(req_ready == 1'b1, "R1 ready after reset", {63'd0, req_ready}, 64'd1);
    chk(!rsp_valid && !mem_req && !mem_lock, "R1 idle outputs after reset",
        {61'd0, rsp_valid, mem_req, mem_lock}, 64'd0);
  endtask

  task automatic t_add_dword;
    bm[1] = 64'h0000_0001_FFFF_FFFF;
    run(64'h100, 16'h0008, 2'b11, 32'h00, 64'h1, 64'h0);
    chk(bm[1] == 64'h0000_0002_0000_0000, "R3 add dword memory", bm[1], 64'h0000_0002_0000_0000);
    chk(!r_wsrc && !r_wr0 && !r_err, "R3 no writeback without fetch", {61'd0, r_wsrc, r_wr0, r_err}, 64'd0);
    chk(r_lat == 8, "R11 latency D=1", r_lat, 8);
    chk(wr_lock == 1'b1, "R10 lock at write", {63'd0, wr_lock}, 64'd1);
    chk(r_busy, "R1 ready low while busy", {63'd0, r_busy}, 64'd1);
  endtask

  task automatic t_add_word_fetch;
    bm[2] = 64'hDEAD_BEEF_FFFF_FFFF;
    run(64'h110, 16'h0000, 2'b00, 32'h01, 64'hAAAA_0000_0000_0002, 64'h0);
    chk(bm[2] == 64'hDEAD_BEEF_0000_0001, "R8 word add wraps in low half", bm[2], 64'hDEAD_BEEF_0000_0001);
    chk(r_data == 64'h0000_0000_FFFF_FFFF && r_wsrc, "R4 fetch old zero-extended",
        r_data, 64'h0000_0000_FFFF_FFFF);
  endtask

  task automatic t_logic_ops;
    bm[3] = 64'hF0F0_0000_1234_5678;
    run(64'h118, 16'h0000, 2'b11, 32'h41, 64'h0F00_0000_0000_0001, 64'h0);
    chk(bm[3] == 64'hFFF0_0000_1234_5679, "R4 or fetch memory", bm[3], 64'hFFF0_0000_1234_5679);
    chk(r_data == 64'hF0F0_0000_1234_5678 && r_wsrc, "R4 or fetch old", r_data, 64'hF0F0_0000_1234_5678);
    run(64'h118, 16'h0000, 2'b11, 32'h50, 64'hFF00_0000_0000_FFFF, 64'h0);
    chk(bm[3] == 64'hFF00_0000_0000_5679, "R3 and memory", bm[3], 64'hFF00_0000_0000_5679);
    run(64'h118, 16'h0000, 2'b11, 32'hA1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
    chk(bm[3] == 64'h00FF_FFFF_FFFF_A986, "R4 xor fetch memory", bm[3], 64'h00FF_FFFF_FFFF_A986);
    chk(r_data == 64'hFF00_0000_0000_5679, "R4 xor fetch old", r_data, 64'hFF00_0000_0000_5679);
  endtask

  task automatic t_xchg;
    bm[4] = 64'h1111_2222_3333_4444;
    run(64'h120, 16'h0000, 2'b11, 32'hE1, 64'h5555_6666_7777_8888, 64'h0);
    chk(bm[4] == 64'h5555_6666_7777_8888, "R5 xchg memory", bm[4], 64'h5555_6666_7777_8888);
    chk(r_data == 64'h1111_2222_3333_4444 && r_wsrc && !r_wr0, "R5 xchg old to src",
        r_data, 64'h1111_2222_3333_4444);
  endtask

  task automatic t_cmpx_hit_word;
    bm[5] = 64'h9999_9999_0000_00AB;
    run(64'h128, 16'h0000, 2'b00, 32'hF1, 64'h0000_0000_CAFE_0001, 64'hFFFF_0000_0000_00AB);
    chk(bm[5] == 64'h9999_9999_CAFE_0001, "R6 cmpxchg match writes", bm[5], 64'h9999_9999_CAFE_0001);
    chk(r_data == 64'h0000_0000_0000_00AB && r_wr0 && !r_wsrc, "R6 old to r0",
        r_data, 64'h0000_0000_0000_00AB);
    chk(r_nwr == 1, "R6 one write", r_nwr, 1);
  endtask

  task automatic t_cmpx_miss;
    bm[6] = 64'h0000_0000_0000_0007;
    run(64'h130, 16'h0000, 2'b11, 32'hF1, 64'h1234, 64'h8);
    chk(bm[6] == 64'h7, "R7 miss leaves memory", bm[6], 64'h7);
    chk(r_nwr == 0 && r_nreq == 1, "R7 only the read issued", r_nreq, 1);
    chk(r_lat == 5, "R7 miss latency", r_lat, 5);
    chk(r_data == 64'h7 && r_wr0, "R7 old still to r0", r_data, 64'h7);
    chk(!mem_lock, "R7 lock released", {63'd0, mem_lock}, 64'd0);
  endtask

  task automatic t_illegal;
    run(64'h100, 16'h0000, 2'b11, 32'h02, 64'h1, 64'h0);
    chk(r_err && r_lat == 1 && r_nreq == 0, "R9 bad imm 0x02", r_lat, 1);
    chk(r_data == 64'h0, "R9 error data zero", r_data, 64'h0);
    run(64'h100, 16'h0000, 2'b11, 32'hE0, 64'h1, 64'h0);
    chk(r_err && r_nreq == 0, "R9 bad imm 0xE0", r_nreq, 0);
    run(64'h100, 16'h0000, 2'b01, 32'h00, 64'h1, 64'h0);
    chk(r_err && r_nreq == 0, "R9 bad size 01", {63'd0, r_err}, 64'd1);
    run(64'h100, 16'h0000, 2'b11, 32'h0000_0100, 64'h1, 64'h0);
    chk(r_err && r_nreq == 0, "R9 high imm bits", {63'd0, r_err}, 64'd1);
  endtask

  task automatic t_neg_offset;
    bm[15] = 64'h10;
    run(64'h200, 16'hFFF8, 2'b11, 32'h00, 64'h5, 64'h0);
    chk(bm[15] == 64'h15, "R2 negative offset slot", bm[15], 64'h15);
  endtask

  task automatic t_slow_mem;
    ack_delay = 3;
    bm[7] = 64'h40;
    run(64'h138, 16'h0000, 2'b11, 32'h01, 64'h2, 64'h0);
    chk(r_lat == 12, "R11 latency D=3", r_lat, 12);
    chk(bm[7] == 64'h42 && r_data == 64'h40, "R11 slow memory result", bm[7], 64'h42);
    ack_delay = 1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0;
    req_base = '0; req_offset = '0; req_size = '0; req_imm = '0;
    req_src = '0; req_r0 = '0;
    for (int i = 0; i < 16; i++) bm[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_add_dword();
    t_add_word_fetch();
    t_logic_ops();
    t_xchg();
    t_cmpx_hit_word();
    t_cmpx_miss();
    t_illegal();
    t_neg_offset();
    t_slow_mem();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule